// File: doc/BRIEF.md
# Edge-Pulse Level Link Codec

This block moves one slowly changing digital level across a modelled isolation gap over two pulse wires. One wire carries a "go high" pulse and the other a "go low" pulse. The sending half watches its input level. When the level changes, it emits a one-cycle pulse on the matching wire. When the level stays still for a whole refresh interval, it re-sends the current level so the far side stays correct at DC.

The receiving half is a bistable latch that the pulses set and clear. A silence timer runs beside it. If no usable pulse arrives for a watchdog interval, the timer forces the output to a parameterised default level and raises a stale flag. This fallback is meant for a sender that is unpowered or starting up. A healthy sender refreshes often enough that it never fires.

Both halves share one clock and one reset, but they have separate ports. A system can route the pulse wires through whatever models the gap. A bench can cut the wires or corrupt them.

Top module: `epl_link`

## Requirements
- R1: A change of `tx_level_i` that is sampled at a clock edge produces a pulse in the following cycle. A change to 1 pulses `tx_set_o` and a change to 0 pulses `tx_clr_o`. The first comparison after reset is made against `DEFAULT_LVL`.
- R2: Each encoder pulse lasts exactly one cycle, and `tx_set_o` and `tx_clr_o` are never high together.
- R3: Counting from the cycle in which the last encoder pulse is visible, if the input does not change, a refresh pulse that carries the current level appears exactly `REFRESH_CYC` cycles later. It repeats with that period while the input stays idle.
- R4: When an input change is sampled on the same edge that a refresh falls due, the pulse carries the new level. An input change at any time restarts the refresh interval from its own pulse.
- R5: A valid pulse, meaning exactly one of `rx_set_i` and `rx_clr_i` is high at an edge, sets `rx_level_o` to 1 (set) or 0 (clear) in the next cycle. Between pulses the level holds.
- R6: If no valid pulse is sampled for `WDOG_CYC` consecutive edges, `rx_stale_o` goes to 1 and `rx_level_o` goes to `DEFAULT_LVL` (1 by default) in that cycle. Both stay there while the silence lasts.
- R7: A valid pulse that arrives while stale clears `rx_stale_o` and applies the pulse's level in the very next cycle.
- R8: `rx_set_i` and `rx_clr_i` high on the same edge count as no pulse. The level is unchanged, and the silence timer is not restarted.
- R9: While reset is applied, `tx_set_o` and `tx_clr_o` are 0, `rx_level_o` equals `DEFAULT_LVL`, and `rx_stale_o` is 1.
- R10: With the pulse wires looped back, `rx_level_o` follows `tx_level_i` two cycles after each change. `rx_stale_o` stays 0 during arbitrarily long idle periods, because `WDOG_CYC` is larger than `REFRESH_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_level_i | input | 1 | Level to be carried across the link |
| tx_set_o | output | 1 | One-cycle pulse meaning "level is high" |
| tx_clr_o | output | 1 | One-cycle pulse meaning "level is low" |
| rx_set_i | input | 1 | Received "level is high" pulse |
| rx_clr_i | input | 1 | Received "level is low" pulse |
| rx_level_o | output | 1 | Reconstructed level |
| rx_stale_o | output | 1 | High while the link has been silent for the watchdog interval |

## Verification
The checker assumes that `tx_level_i` is synchronous to `clk`, because the encoder compares it with its registered copy once per edge. It also assumes that `WDOG_CYC` exceeds `REFRESH_CYC`, so a looped-back link never reaches the watchdog. The bench drives every input at the falling edge and keeps the default intervals. It uses its direct pulse injection only while the loopback is cut, so the decoder sees either real encoder traffic or deliberate stimulus, never both at once.

// File: rtl/epl_pkg.sv
package epl_pkg;

  typedef enum logic [1:0] {
    PULSE_NONE = 2'b00,
    PULSE_SET  = 2'b01,
    PULSE_CLR  = 2'b10
  } pulse_e;

  function automatic pulse_e pulse_for_level(input logic lvl);
    return lvl ? PULSE_SET : PULSE_CLR;
  endfunction

  function automatic logic pulse_is_valid(input logic set_b, input logic clr_b);
    return set_b ^ clr_b;
  endfunction

endpackage

// File: rtl/epl_rst_sync.sv
module epl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/epl_interval_timer.sv
module epl_interval_timer #(
  parameter int LIMIT    = 50,
  parameter bit SATURATE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] end_val;

  generate
    if (SATURATE) begin : g_sat
      assign end_val = LAST;
    end else begin : g_wrap
      assign end_val = '0;
    end
  endgenerate

  assign expire = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (expire) cnt_d = end_val;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epl_encoder.sv
module epl_encoder
  import epl_pkg::*;
#(
  parameter int   REFRESH_CYC = 50,
  parameter logic DEFAULT_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic set_o,
  output logic clr_o
);
  logic   prev_q, prev_d;
  pulse_e pulse_q, pulse_d;
  logic   changed;
  logic   refresh_due;

  assign changed = (level_i != prev_q);

  epl_interval_timer #(.LIMIT(REFRESH_CYC), .SATURATE(1'b0)) u_refresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(changed),
    .expire (refresh_due)
  );

  always_comb begin
    prev_d  = level_i;
    pulse_d = PULSE_NONE;
    if (changed || refresh_due) pulse_d = pulse_for_level(level_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= DEFAULT_LVL;
      pulse_q <= PULSE_NONE;
    end else begin
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign set_o = (pulse_q == PULSE_SET);
  assign clr_o = (pulse_q == PULSE_CLR);
endmodule

// File: rtl/epl_decoder.sv
module epl_decoder
  import epl_pkg::*;
#(
  parameter int   WDOG_CYC    = 250,
  parameter logic DEFAULT_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o,
  output logic stale_o
);
  logic valid;
  logic lapsed;
  logic level_q, level_d;
  logic stale_q, stale_d;

  assign valid = pulse_is_valid(set_i, clr_i);

  epl_interval_timer #(.LIMIT(WDOG_CYC), .SATURATE(1'b1)) u_silence (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(valid),
    .expire (lapsed)
  );

  always_comb begin
    level_d = level_q;
    stale_d = stale_q;
    if (valid) begin
      level_d = set_i;
      stale_d = 1'b0;
    end else if (lapsed) begin
      level_d = DEFAULT_LVL;
      stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= DEFAULT_LVL;
      stale_q <= 1'b1;
    end else begin
      level_q <= level_d;
      stale_q <= stale_d;
    end
  end

  assign level_o = level_q;
  assign stale_o = stale_q;
endmodule

// File: rtl/epl_link.sv
module epl_link #(
  parameter int   REFRESH_CYC = 50,
  parameter int   WDOG_CYC    = 250,
  parameter logic DEFAULT_LVL = 1'b1,
  parameter int   SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_level_i,
  output logic tx_set_o,
  output logic tx_clr_o,
  input  logic rx_set_i,
  input  logic rx_clr_i,
  output logic rx_level_o,
  output logic rx_stale_o
);
  logic rst_sync_n;

  epl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  epl_encoder #(.REFRESH_CYC(REFRESH_CYC), .DEFAULT_LVL(DEFAULT_LVL)) u_enc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .level_i(tx_level_i),
    .set_o  (tx_set_o),
    .clr_o  (tx_clr_o)
  );

  epl_decoder #(.WDOG_CYC(WDOG_CYC), .DEFAULT_LVL(DEFAULT_LVL)) u_dec (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (rx_set_i),
    .clr_i  (rx_clr_i),
    .level_o(rx_level_o),
    .stale_o(rx_stale_o)
  );
endmodule

// File: rtl/epl_link_checker.sv
module epl_link_checker #(
  parameter int   REFRESH_CYC = 50,
  parameter logic DEFAULT_LVL = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic tx_level_i,
  input logic tx_set_o,
  input logic tx_clr_o,
  input logic rx_set_i,
  input logic rx_clr_i,
  input logic rx_level_o,
  input logic rx_stale_o
);
  localparam int GW = $clog2(REFRESH_CYC + 2);

  logic [1:0]    armed_q;
  logic [GW-1:0] gap_q;
  logic          live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= '0;
    else        armed_q <= {armed_q[0], 1'b1};
  end
  assign live = armed_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gap_q <= '0;
    else if (tx_set_o || tx_clr_o)    gap_q <= '0;
    else if (gap_q != GW'(REFRESH_CYC + 1)) gap_q <= gap_q + 1'b1;
  end

  p_edge_pulse_r1: assert property (@(posedge clk) disable iff (!live)
    (tx_level_i != $past(tx_level_i)) |=>
      (tx_set_o == $past(tx_level_i)) && (tx_clr_o == !$past(tx_level_i)));

  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set_o && tx_clr_o));

  p_single_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set_o |=> !tx_set_o);

  p_single_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr_o |=> !tx_clr_o);

  p_refresh_gap_r3: assert property (@(posedge clk) disable iff (!live)
    gap_q <= GW'(REFRESH_CYC));

  p_hold_r5: assert property (@(posedge clk) disable iff (!live)
    !(rx_set_i ^ rx_clr_i) |=> (rx_level_o == $past(rx_level_o)) || rx_stale_o);

  p_stale_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stale_o |-> (rx_level_o == DEFAULT_LVL));

  p_valid_applies_r7: assert property (@(posedge clk) disable iff (!live)
    (rx_set_i ^ rx_clr_i) |=> !rx_stale_o && (rx_level_o == $past(rx_set_i)));

  p_both_ignored_r8: assert property (@(posedge clk) disable iff (!live)
    (rx_set_i && rx_clr_i) |=> $stable(rx_level_o) || rx_stale_o);
endmodule

bind epl_link epl_link_checker #(
  .REFRESH_CYC(REFRESH_CYC),
  .DEFAULT_LVL(DEFAULT_LVL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tx_level_i(tx_level_i),
  .tx_set_o  (tx_set_o),
  .tx_clr_o  (tx_clr_o),
  .rx_set_i  (rx_set_i),
  .rx_clr_i  (rx_clr_i),
  .rx_level_o(rx_level_o),
  .rx_stale_o(rx_stale_o)
);

// File: tb/epl_link_bench.sv
module epl_link_bench;
  localparam int   R   = 50;
  localparam int   W   = 250;
  localparam logic DEF = 1'b1;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_level, tx_set, tx_clr;
  logic inj_set, inj_clr, link_on;
  logic rx_set, rx_clr, rx_level, rx_stale;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit both_seen = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    bit    is_rx;
    logic  a;
    logic  b;
    string rq;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rx_set = link_on ? tx_set : inj_set;
  assign rx_clr = link_on ? tx_clr : inj_clr;

  epl_link #(.REFRESH_CYC(R), .WDOG_CYC(W), .DEFAULT_LVL(DEF)) u_epl_link (
    .clk(clk), .rst_n(rst_n), .tx_level_i(tx_level),
    .tx_set_o(tx_set), .tx_clr_o(tx_clr),
    .rx_set_i(rx_set), .rx_clr_i(rx_clr),
    .rx_level_o(rx_level), .rx_stale_o(rx_stale)
  );

  task automatic check(string rq, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", rq, what, cyc, act, exp);
    end
  endtask

  function automatic void push(int c, bit rx, logic a, logic b, string rq);
    exp_t it;
    int i = 0;
    it = '{c, rx, a, b, rq};
    while (i < q.size() && q[i].cyc <= c) i++;
    q.insert(i, it);
  endfunction

  always @(negedge clk) begin
    exp_t it;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      if (it.is_rx) check(it.rq, "rx level/stale", {rx_level, rx_stale}, {it.a, it.b});
      else          check(it.rq, "tx set/clr",     {tx_set, tx_clr},     {it.a, it.b});
    end
    if (tx_set === 1'b1 && tx_clr === 1'b1) both_seen = 1;
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic toggle(logic v, string rq);
    int n = cyc;
    tx_level = v;
    push(n + 1, 0, v, !v, rq);
    push(n + 2, 0, 1'b0, 1'b0, rq);
    if (link_on) push(n + 2, 1, v, 1'b0, "R10");
  endtask

  task automatic inject(logic s, logic c);
    inj_set = s; inj_clr = c;
    @(negedge clk);
    inj_set = 1'b0; inj_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n0, e, t, c, d;
    tx_level = 1'b1; link_on = 1'b1; inj_set = 1'b0; inj_clr = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: state while in reset
    check("R9", "tx set/clr in reset", {tx_set, tx_clr}, 2'b00);
    check("R9", "rx level/stale in reset", {rx_level, rx_stale}, {DEF, 1'b1});
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9", "no pulse when input equals default", {tx_set, tx_clr}, 2'b00);

    // R1: edges in both directions
    toggle(1'b0, "R1"); repeat (5) @(negedge clk);
    toggle(1'b1, "R1"); repeat (5) @(negedge clk);
    n0 = cyc;
    toggle(1'b0, "R1");

    // R3: periodic refresh while idle
    push(n0 + R,         0, 1'b0, 1'b0, "R3");
    push(n0 + 1 + R,     0, 1'b0, 1'b1, "R3");
    push(n0 + 2 + R,     0, 1'b0, 1'b0, "R3");
    push(n0 + 1 + 2 * R, 0, 1'b0, 1'b1, "R3");
    push(n0 + 2 + 2 * R, 1, 1'b0, 1'b0, "R10");

    // R4: edge sampled on the refresh-due edge
    wait_to(n0 + 3 * R);
    tx_level = 1'b1;
    e = n0 + 1 + 3 * R;
    push(e,     0, 1'b1, 1'b0, "R4");
    push(e + 1, 0, 1'b0, 1'b0, "R4");
    push(e + 1, 1, 1'b1, 1'b0, "R10");
    // R4: edge one cycle before due restarts the interval
    wait_to(e + R - 2);
    tx_level = 1'b0;
    push(e + R - 1,     0, 1'b0, 1'b1, "R4");
    push(e + R,         0, 1'b0, 1'b0, "R4");
    push(e + 2 * R - 2, 0, 1'b0, 1'b0, "R3");
    push(e + 2 * R - 1, 0, 1'b0, 1'b1, "R3");

    // R10: long idle with loopback keeps the link alive
    wait_to(e + 2 * R);
    t = cyc;
    push(t + W,     1, 1'b0, 1'b0, "R10");
    push(t + 2 * W, 1, 1'b0, 1'b0, "R10");
    push(t + 3 * W, 1, 1'b0, 1'b0, "R10");
    wait_to(t + 3 * W + 1);

    // Decoder alone: R5, R8, R6, R7
    link_on = 1'b0;
    c = cyc;
    inject(1'b1, 1'b0);
    push(c + 1, 1, 1'b1, 1'b0, "R5");
    push(c + 6, 1, 1'b1, 1'b0, "R5");
    wait_to(c + 10);
    inject(1'b0, 1'b1);
    push(c + 11, 1, 1'b0, 1'b0, "R5");
    wait_to(c + 30);
    inject(1'b1, 1'b1);
    push(c + 31,    1, 1'b0, 1'b0, "R8");
    push(c + 40,    1, 1'b0, 1'b0, "R8");
    push(c + 10 + W, 1, 1'b0, 1'b0, "R6");
    push(c + 11 + W, 1, DEF, 1'b1, "R6");
    push(c + 20 + W, 1, DEF, 1'b1, "R6");
    wait_to(c + 11 + W + 15);
    d = cyc;
    inject(1'b0, 1'b1);
    push(d + 1, 1, 1'b0, 1'b0, "R7");
    push(d + 3, 1, 1'b0, 1'b0, "R7");

    // Reconnect and follow level changes
    wait_to(d + 10);
    link_on = 1'b1;
    repeat (3) @(negedge clk);
    toggle(1'b1, "R10"); repeat (8) @(negedge clk);
    toggle(1'b0, "R10"); repeat (4) @(negedge clk);
    toggle(1'b1, "R1");

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R2", "set and clear never together", {1'b0, both_seen}, 2'b00);
    finish_run();
  end
endmodule